// File: doc/BRIEF.md
# DAC Sample Calibration Pipeline

This block sits between a per-channel sample buffer and the serial link that feeds an eight-channel digital-to-analog converter array. Each incoming 16-bit host code arrives with a channel tag and with that channel's gain and offset correction words. The coefficient RAM supplies these words, and that RAM lies outside the block. The block scales the code by one plus a small signed gain error, adds a quarter of the signed offset error, and adds a fixed bias for the output range in use. It can also add a further lift that positions the code ahead of the serial link. The sum is clamped into the 16-bit code space.

The gain error carries 18 fractional bits, so one gain step equals 2^-18 of the sample. The gain term is rounded to the nearest code, with exact halves rounded upward. The offset term is the offset error shifted right by two places arithmetically, which takes the floor of a division by four. The unipolar 0 to 10 V range adds 32768. The bipolar ±5 V range adds nothing. The two-stage pipeline accepts a new sample on every clock cycle.

Top module: `dac_cal_datapath`

## Requirements
- R1: A sample taken with `in_valid` high at one rising edge appears with `out_valid` high exactly two rising edges later. Back-to-back samples give back-to-back results, and `out_valid` is never high without such a sample.
- R2: While `rst` is high and after it is released, `out_valid`, `out_code` and `out_chan` are all zero until the first result.
- R3: With the bipolar range (`range_sel`=0), zero gain, zero offset and `lift_en`=0, `out_code` equals `in_sample`.
- R4: The gain term adds floor((D*G + 2^17) / 2^18). D is the unsigned sample and G is `gain_err` read as signed 16-bit two's complement. This rounds to nearest, and exact halves round toward plus infinity.
- R5: The offset term adds floor(O/4), where O is `offset_err` read as signed 16-bit two's complement.
- R6: `range_sel`=1 selects the unipolar range and adds 32768. `range_sel`=0 selects the bipolar range and adds 0.
- R7: `lift_en`=1 adds a further 16384 to the sum.
- R8: A sum above 65535 gives 65535, and a sum below 0 gives 0. Neither wraps around.
- R9: `out_chan` carries the `in_chan` value of the sample whose result is on `out_code`.
- R10: Between results, `out_code` and `out_chan` keep their last values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Sample strobe |
| in_sample | input | 16 | Raw unsigned host code |
| in_chan | input | 3 | Channel tag of the sample |
| gain_err | input | 16 | Signed gain error, weighted by 2^-18 |
| offset_err | input | 16 | Signed offset error, weighted by 1/4 |
| range_sel | input | 1 | 1 selects unipolar (+32768), 0 selects bipolar |
| lift_en | input | 1 | Adds 16384 ahead of the serial link |
| out_valid | output | 1 | Corrected result strobe |
| out_code | output | 16 | Corrected, clamped code |
| out_chan | output | 3 | Channel tag of the result |

## Verification
The bench targets the rounding boundary with products that land on exactly half a code, for both signs. A design that truncates instead of rounding, or that rounds halves toward zero, gives results off by one there. It drives negative odd offsets, where a logical shift or a truncating divide gives a wrong sign or a result off by one. It pushes sums past 65535 and below zero, where a wrapping adder shows a small or huge code instead of the clamp value. It streams samples back to back on different channels, which shows pipeline stalls, lost tags and latency off by one cycle.

// File: rtl/dac_cal_pkg.sv
package dac_cal_pkg;
  typedef enum logic {
    RANGE_BIPOLAR  = 1'b0,
    RANGE_UNIPOLAR = 1'b1
  } range_e;
endpackage

// File: rtl/cal_product_stage.sv
// First stage: full-precision gain product plus the additive base term.
module cal_product_stage
  import dac_cal_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int COEF_W    = 16,
  parameter int CHAN_W    = 3,
  parameter int OFF_SHIFT = 2,
  parameter int UNI_BIAS  = 32768,
  parameter int LIFT_BIAS = 16384,
  parameter int PROD_W    = DATA_W + COEF_W + 1,
  parameter int BASE_W    = DATA_W + 3
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     in_valid,
  input  logic [DATA_W-1:0]        in_sample,
  input  logic [CHAN_W-1:0]        in_chan,
  input  logic signed [COEF_W-1:0] gain_err,
  input  logic signed [COEF_W-1:0] offset_err,
  input  range_e                   range_sel,
  input  logic                     lift_en,
  output logic                     s1_valid,
  output logic [CHAN_W-1:0]        s1_chan,
  output logic signed [PROD_W-1:0] s1_prod,
  output logic signed [BASE_W-1:0] s1_base
);
  localparam logic signed [BASE_W-1:0] UNI_K  = BASE_W'(UNI_BIAS);
  localparam logic signed [BASE_W-1:0] LIFT_K = BASE_W'(LIFT_BIAS);

  logic signed [PROD_W-1:0] prod_c;
  logic signed [BASE_W-1:0] data_x, off_c, bias_c, base_c;

  always_comb begin
    prod_c = PROD_W'($signed({1'b0, in_sample})) * PROD_W'(gain_err);
    data_x = BASE_W'($signed({1'b0, in_sample}));
    off_c  = BASE_W'(offset_err) >>> OFF_SHIFT;
    bias_c = (range_sel == RANGE_UNIPOLAR) ? UNI_K : '0;
    if (lift_en) bias_c = bias_c + LIFT_K;
    base_c = data_x + off_c + bias_c;
  end

  always_ff @(posedge clk) begin
    if (rst) s1_valid <= 1'b0;
    else     s1_valid <= in_valid;
  end

  always_ff @(posedge clk) begin
    if (in_valid) begin
      s1_chan <= in_chan;
      s1_prod <= prod_c;
      s1_base <= base_c;
    end
  end

  // R5: a negative offset never raises the base above data plus biases
  a_r5_offset_sign: assert property (@(posedge clk) disable iff (rst)
    (in_valid && offset_err < 0) |=> (s1_base < data_x_q + bias_q + 1));

  logic signed [BASE_W-1:0] data_x_q, bias_q;
  always_ff @(posedge clk) begin
    if (in_valid) begin
      data_x_q <= data_x;
      bias_q   <= bias_c;
    end
  end
endmodule

// File: rtl/cal_round_sat.sv
// Second stage: round the gain term, add the base, clamp and register.
module cal_round_sat #(
  parameter int DATA_W    = 16,
  parameter int CHAN_W    = 3,
  parameter int GAIN_FRAC = 18,
  parameter int PROD_W    = 33,
  parameter int BASE_W    = 19
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     s1_valid,
  input  logic [CHAN_W-1:0]        s1_chan,
  input  logic signed [PROD_W-1:0] s1_prod,
  input  logic signed [BASE_W-1:0] s1_base,
  output logic                     out_valid,
  output logic [DATA_W-1:0]        out_code,
  output logic [CHAN_W-1:0]        out_chan
);
  localparam int SUM_W = PROD_W + 1;
  localparam logic signed [SUM_W-1:0] HALF_K   = SUM_W'(1) <<< (GAIN_FRAC - 1);
  localparam logic signed [SUM_W-1:0] CODE_MAX = SUM_W'((1 << DATA_W) - 1);

  logic signed [SUM_W-1:0] gterm_c, sum_c;
  logic [DATA_W-1:0]       code_c;

  always_comb begin
    gterm_c = (SUM_W'(s1_prod) + HALF_K) >>> GAIN_FRAC;
    sum_c   = SUM_W'(s1_base) + gterm_c;
    if (sum_c < 0)              code_c = '0;
    else if (sum_c > CODE_MAX)  code_c = '1;
    else                        code_c = sum_c[DATA_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_code  <= '0;
      out_chan  <= '0;
    end else begin
      out_valid <= s1_valid;
      if (s1_valid) begin
        out_code <= code_c;
        out_chan <= s1_chan;
      end
    end
  end

  // R8: clamp at both ends of the code space
  a_r8_clamp_low: assert property (@(posedge clk) disable iff (rst)
    (s1_valid && sum_c < 0) |=> (out_code == '0));
  a_r8_clamp_high: assert property (@(posedge clk) disable iff (rst)
    (s1_valid && sum_c > CODE_MAX) |=> (&out_code));
  // R10: results hold while no new one arrives
  a_r10_hold: assert property (@(posedge clk) disable iff (rst)
    !s1_valid |=> ($stable(out_code) && $stable(out_chan)));
endmodule

// File: rtl/dac_cal_datapath.sv
module dac_cal_datapath
  import dac_cal_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int COEF_W    = 16,
  parameter int CHAN_W    = 3,
  parameter int GAIN_FRAC = 18,
  parameter int OFF_SHIFT = 2,
  parameter int UNI_BIAS  = 32768,
  parameter int LIFT_BIAS = 16384
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_sample,
  input  logic [CHAN_W-1:0] in_chan,
  input  logic [COEF_W-1:0] gain_err,
  input  logic [COEF_W-1:0] offset_err,
  input  logic              range_sel,
  input  logic              lift_en,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_code,
  output logic [CHAN_W-1:0] out_chan
);
  localparam int PROD_W = DATA_W + COEF_W + 1;
  localparam int BASE_W = DATA_W + 3;

  logic                     s1_valid;
  logic [CHAN_W-1:0]        s1_chan;
  logic signed [PROD_W-1:0] s1_prod;
  logic signed [BASE_W-1:0] s1_base;

  cal_product_stage #(
    .DATA_W(DATA_W), .COEF_W(COEF_W), .CHAN_W(CHAN_W), .OFF_SHIFT(OFF_SHIFT),
    .UNI_BIAS(UNI_BIAS), .LIFT_BIAS(LIFT_BIAS), .PROD_W(PROD_W), .BASE_W(BASE_W)
  ) i_prod (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sample(in_sample),
    .in_chan(in_chan), .gain_err($signed(gain_err)), .offset_err($signed(offset_err)),
    .range_sel(range_e'(range_sel)), .lift_en(lift_en),
    .s1_valid(s1_valid), .s1_chan(s1_chan), .s1_prod(s1_prod), .s1_base(s1_base)
  );

  cal_round_sat #(
    .DATA_W(DATA_W), .CHAN_W(CHAN_W), .GAIN_FRAC(GAIN_FRAC),
    .PROD_W(PROD_W), .BASE_W(BASE_W)
  ) i_rsat (
    .clk(clk), .rst(rst), .s1_valid(s1_valid), .s1_chan(s1_chan),
    .s1_prod(s1_prod), .s1_base(s1_base),
    .out_valid(out_valid), .out_code(out_code), .out_chan(out_chan)
  );

  // R1: fixed two-edge latency, no spurious results
  a_r1_latency: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> ##1 out_valid);
  a_r1_no_spurious: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(in_valid, 2));
  // R3: neutral settings pass the sample straight through
  a_r3_identity: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !range_sel && !lift_en && gain_err == '0 && offset_err == '0)
      |=> ##1 (out_code == $past(in_sample, 2)));
  // R9: channel tag follows its sample
  a_r9_chan_tag: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> ##1 (out_chan == $past(in_chan, 2)));
endmodule

// File: tb/test_dac_cal_datapath.sv
module test_dac_cal_datapath;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [15:0] in_sample = '0;
  logic [2:0]  in_chan = '0;
  logic [15:0] gain_err = '0;
  logic [15:0] offset_err = '0;
  logic        range_sel = 1'b0;
  logic        lift_en = 1'b0;
  logic        out_valid;
  logic [15:0] out_code;
  logic [2:0]  out_chan;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dac_cal_datapath i_dac_cal_datapath (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sample(in_sample),
    .in_chan(in_chan), .gain_err(gain_err), .offset_err(offset_err),
    .range_sel(range_sel), .lift_en(lift_en),
    .out_valid(out_valid), .out_code(out_code), .out_chan(out_chan)
  );

  function automatic int model(int d, int g, int o, bit uni, bit lift);
    longint p, gt;
    int s;
    p  = longint'(d) * longint'(g);
    gt = (p + 64'sd131072) >>> 18;
    s  = d + int'(gt) + (o >>> 2) + (uni ? 32768 : 0) + (lift ? 16384 : 0);
    if (s < 0) s = 0;
    if (s > 65535) s = 65535;
    return s;
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic drive(int d, int g, int o, bit uni, bit lift, int ch);
    in_valid   = 1'b1;
    in_sample  = 16'(d);
    gain_err   = 16'(g);
    offset_err = 16'(o);
    range_sel  = uni;
    lift_en    = lift;
    in_chan    = 3'(ch);
  endtask

  // one sample, checked two edges later
  task automatic run_one(string req, int d, int g, int o, bit uni, bit lift, int ch);
    @(negedge clk); drive(d, g, o, uni, lift, ch);
    @(negedge clk); in_valid = 1'b0;
    @(negedge clk);
    chk({req, " valid"}, int'(out_valid), 1);
    chk(req, int'(out_code), model(d, g, o, uni, lift));
    chk({req, " R9 chan"}, int'(out_chan), ch);
  endtask

  task automatic t_reset();
    chk("R2 valid", int'(out_valid), 0);
    chk("R2 code", int'(out_code), 0);
    chk("R2 chan", int'(out_chan), 0);
  endtask

  task automatic t_identity();
    run_one("R3 identity", 12345, 0, 0, 0, 0, 3);
    run_one("R3 identity max", 65535, 0, 0, 0, 0, 6);
  endtask

  task automatic t_gain();
    run_one("R4 gain pos", 40000, 32767, 0, 0, 0, 1);
    run_one("R4 gain neg", 50000, -32768, 0, 0, 0, 2);
    run_one("R4 half up", 8, 16384, 0, 0, 0, 4);
    chk("R4 half up value", int'(out_code), 9);
    run_one("R4 half neg", 8, -16384, 0, 0, 0, 5);
    chk("R4 half neg value", int'(out_code), 8);
    run_one("R4 one and half", 24, 16384, 0, 0, 0, 7);
  endtask

  task automatic t_offset();
    run_one("R5 neg odd", 1000, 0, -7, 0, 0, 0);
    chk("R5 neg odd value", int'(out_code), 998);
    run_one("R5 pos odd", 1000, 0, 7, 0, 0, 1);
  endtask

  task automatic t_range_lift();
    run_one("R6 unipolar", 100, 0, 0, 1, 0, 2);
    chk("R6 unipolar value", int'(out_code), 32868);
    run_one("R7 lift", 100, 0, 0, 0, 1, 3);
    chk("R7 lift value", int'(out_code), 16484);
    run_one("R7 lift unipolar", 100, 0, 0, 1, 1, 4);
  endtask

  task automatic t_saturate();
    run_one("R8 high", 65535, 0, 0, 1, 0, 5);
    chk("R8 high value", int'(out_code), 65535);
    run_one("R8 high lift", 40000, 1000, 100, 1, 1, 6);
    run_one("R8 low", 0, 0, -4, 0, 0, 7);
    chk("R8 low value", int'(out_code), 0);
    run_one("R8 low big", 1, -32768, -32768, 0, 0, 0);
  endtask

  task automatic t_hold();
    logic [15:0] code_q;
    logic [2:0]  chan_q;
    run_one("R10 setup", 777, 123, -9, 0, 0, 5);
    code_q = out_code;
    chan_q = out_chan;
    repeat (3) @(negedge clk);
    chk("R10 valid low", int'(out_valid), 0);
    chk("R10 code held", int'(out_code), int'(code_q));
    chk("R10 chan held", int'(out_chan), int'(chan_q));
  endtask

  task automatic t_stream();
    int d[6] = '{100, 60000, 3, 32768, 999, 45000};
    int g[6] = '{-100, 2000, 16384, -32768, 0, 32767};
    int o[6] = '{5, -3, 0, 400, -1, -32768};
    bit u[6] = '{0, 1, 0, 1, 0, 0};
    bit l[6] = '{1, 0, 0, 0, 1, 0};
    for (int t = 0; t < 8; t++) begin
      @(negedge clk);
      if (t >= 2) begin
        chk("R1 stream valid", int'(out_valid), 1);
        chk("R1 stream code", int'(out_code),
            model(d[t-2], g[t-2], o[t-2], u[t-2], l[t-2]));
        chk("R9 stream chan", int'(out_chan), t - 2);
      end
      if (t < 6) drive(d[t], g[t], o[t], u[t], l[t], t);
      else in_valid = 1'b0;
    end
    @(negedge clk);
    chk("R1 no extra result", int'(out_valid), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_identity();
    t_gain();
    t_offset();
    t_range_lift();
    t_saturate();
    t_hold();
    t_stream();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule